// File: doc/BRIEF.md
# PLL Output Rate Recompute Unit

This block works out the output frequency of a fractional-N PLL from the register settings that program it. It takes three inputs. The first is the reference frequency, as an integer in hertz. The second is the feedback divider word, a fixed-point value whose top `INT_W` bits are the integer part and whose remaining low bits are the fraction. The third is a 3-bit post-divider selector that picks a power-of-two divide from 1 to 128. It returns the resulting output rate.

Both roundings go upward. First the product of reference and divider word is reduced to an integer, and it is bumped by one when any fractional bit is set. Then that value is divided by the post-divider, again with a round up. A controller pulses `start_i` with the operands valid. One cycle later `rate_vld_o` pulses for a single cycle with the result on `rate_o`. The result stays there until the next start.

Top module: `pllrc_top`

## Requirements
- R1: While reset is asserted, and after it is released, `rate_vld_o` is 0 and `rate_o` is 0 until the first start.
- R2: A start sampled at a rising clock edge makes `rate_vld_o` high during the following cycle only, unless start is held, and `rate_o` carries the new result in that same cycle.
- R3: The fractional width F is WORD_W minus INT_W, or 0 when WORD_W is not larger than INT_W. With the defaults (22-bit word, 7 integer bits), F is 15 and the integer part is div_word_i[21:15].
- R4: The intermediate value is P = ref_freq_i × div_word_i at full precision. If P[F-1:0] is zero, the value is P >> F. Otherwise it is (P >> F) + 1.
- R5: post_sel_i = k selects a divide by 2^k, for k = 0 to 7. The output is that intermediate value divided by 2^k and rounded up, so any nonzero remainder adds one.
- R6: Without a start, `rate_o` holds its value and ignores changes on every other input.
- R7: A zero reference or a zero divider word gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sample the operands and compute |
| ref_freq_i | input | REF_W | Reference frequency, integer |
| div_word_i | input | WORD_W | Feedback divider word, fixed point |
| post_sel_i | input | 3 | Post-divide exponent k (divide by 2^k) |
| rate_o | output | OUT_W | Computed output rate |
| rate_vld_o | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest cases to reach are a product whose fractional bits are nonzero but small, and an intermediate value whose remainder modulo 2^k is exactly one. In those cases a single missing increment changes the answer by one count. The vector table builds words with only bit 0 of the fraction set and pairs them with the largest post-divide. Randomly drawn words are then compared against a bench model that does the divisions by ordinary add-then-divide arithmetic rather than by shifting. An all-ones reference and word at k = 7 covers the widest product.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;
   localparam int unsigned PD_W = 3;

   function automatic int unsigned frac_bits(input int unsigned word_w, input int unsigned int_w);
      return (word_w > int_w) ? (word_w - int_w) : 0;
   endfunction
endpackage

// File: rtl/pllrc_frac_ceil.sv
module pllrc_frac_ceil #(
   parameter int unsigned REF_W  = 32,
   parameter int unsigned WORD_W = 22,
   parameter int unsigned FRAC_W = 15,
   parameter int unsigned PROD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REF_W-1:0]  ref_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [PROD_W-1:0] rate_o
);
   logic [PROD_W-1:0] prod;

   assign prod = PROD_W'(ref_i) * PROD_W'(word_i);

   generate
      if (FRAC_W == 0) begin : g_int_only
         assign rate_o = prod;
      end else begin : g_frac
         logic sticky;
         assign sticky = |prod[FRAC_W-1:0];
         assign rate_o = (prod >> FRAC_W) + PROD_W'(sticky);
      end
   endgenerate

   // R4: the result scaled back up covers the product, and one less would not
   a_r4_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (({1'b0, rate_o} << FRAC_W) >= {1'b0, prod}));
   a_r4_tight: assert property (@(posedge clk) disable iff (!rst_n)
      (prod != '0) |-> (({1'b0, rate_o - PROD_W'(1)} << FRAC_W) < {1'b0, prod}));
endmodule

// File: rtl/pllrc_pow2_ceil.sv
module pllrc_pow2_ceil #(
   parameter int unsigned W    = 64,
   parameter int unsigned SH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    val_i,
   input  logic [SH_W-1:0] sh_i,
   output logic [W-1:0]    val_o
);
   localparam int unsigned XW = W + (1 << SH_W);

   logic [W-1:0] low_mask;
   logic         sticky;

   assign low_mask = ~({W{1'b1}} << sh_i);
   assign sticky   = |(val_i & low_mask);
   assign val_o    = (val_i >> sh_i) + W'(sticky);

   // R5: ceiling division by 2^k
   a_r5_covers: assert property (@(posedge clk) disable iff (!rst_n)
      ((XW'(val_o) << sh_i) >= XW'(val_i)));
   a_r5_tight: assert property (@(posedge clk) disable iff (!rst_n)
      (val_i != '0) |-> ((XW'(val_o - W'(1)) << sh_i) < XW'(val_i)));
endmodule

// File: rtl/pllrc_top.sv
module pllrc_top
   import pllrc_pkg::*;
#(
   parameter int unsigned REF_W  = 32,
   parameter int unsigned WORD_W = 22,
   parameter int unsigned INT_W  = 7,
   parameter int unsigned OUT_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [REF_W-1:0]  ref_freq_i,
   input  logic [WORD_W-1:0] div_word_i,
   input  logic [PD_W-1:0]   post_sel_i,
   output logic [OUT_W-1:0]  rate_o,
   output logic              rate_vld_o
);
   localparam int unsigned FRAC_W = frac_bits(WORD_W, INT_W);
   localparam int unsigned PROD_W = (REF_W + WORD_W > 64) ? (REF_W + WORD_W) : 64;

   generate
      if (INT_W < 1) begin : g_bad_int
         $error("pllrc_top: INT_W must be at least 1");
      end
      if (OUT_W < PROD_W) begin : g_bad_out
         $error("pllrc_top: OUT_W must hold the full product");
      end
   endgenerate

   logic [PROD_W-1:0] vco_rate;
   logic [PROD_W-1:0] div_rate;

   pllrc_frac_ceil #(
      .REF_W (REF_W),
      .WORD_W(WORD_W),
      .FRAC_W(FRAC_W),
      .PROD_W(PROD_W)
   ) u_frac (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_i (ref_freq_i),
      .word_i(div_word_i),
      .rate_o(vco_rate)
   );

   pllrc_pow2_ceil #(
      .W   (PROD_W),
      .SH_W(PD_W)
   ) u_post (
      .clk  (clk),
      .rst_n(rst_n),
      .val_i(vco_rate),
      .sh_i (post_sel_i),
      .val_o(div_rate)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_o     <= '0;
         rate_vld_o <= 1'b0;
      end else begin
         rate_vld_o <= start_i;
         if (start_i) rate_o <= OUT_W'(div_rate);
      end
   end

   // R2: valid follows start by one cycle and only then
   a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> rate_vld_o);
   a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !rate_vld_o);
   // R6: result held without a start
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(rate_o));
   // R7: zero operand gives zero
   a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (ref_freq_i == '0 || div_word_i == '0)) |=> (rate_o == '0));
endmodule

// File: tb/pllrc_top_bench.sv
module pllrc_top_bench;
   localparam int unsigned REF_W = 32;
   localparam int unsigned WORD_W = 22;
   localparam int unsigned FR = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [REF_W-1:0]  ref_freq_i = '0;
   logic [WORD_W-1:0] div_word_i = '0;
   logic [2:0]        post_sel_i = '0;
   logic [63:0]       rate_o;
   logic              rate_vld_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pllrc_top u_pllrc_top (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_freq_i(ref_freq_i),
      .div_word_i(div_word_i), .post_sel_i(post_sel_i),
      .rate_o(rate_o), .rate_vld_o(rate_vld_o)
   );

   typedef struct packed {
      logic [31:0] rf;
      logic [21:0] wd;
      logic [2:0]  pd;
      logic [63:0] exp;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'd26000000, 22'(40 << 15),      3'd0, 64'd1040000000}, // R4 exact, no fraction
      '{32'd26000000, 22'(40 << 15),      3'd1, 64'd520000000},  // R5 k=1
      '{32'd3,        22'd1,              3'd0, 64'd1},          // R4 tiny fraction rounds up
      '{32'd3,        22'd1,              3'd7, 64'd1},          // R5 k=7 rounds up
      '{32'd1000,     22'((1 << 15) + 1), 3'd0, 64'd1001},       // R4 sticky
      '{32'd1000,     22'((1 << 15) + 1), 3'd2, 64'd251},        // R5 remainder one
      '{32'd100,      22'(3 << 15),       3'd3, 64'd38},         // R5 remainder half
      '{32'd0,        22'h3FFFFF,         3'd0, 64'd0}           // R7 zero reference
   };

   function automatic longint unsigned model(input longint unsigned rf, input longint unsigned wd,
                                             input int pd);
      longint unsigned p, q, d;
      p = rf * wd;
      q = (p + (64'd1 << FR) - 1) / (64'd1 << FR);
      d = 64'd1 << pd;
      return (q + d - 1) / d;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] rf, input logic [21:0] wd, input logic [2:0] pd,
                      input logic [63:0] exp, input string req);
      @(negedge clk);
      ref_freq_i = rf; div_word_i = wd; post_sel_i = pd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check({req, " valid"}, 64'(rate_vld_o), 64'd1);
      check(req, rate_o, exp);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 valid in reset", 64'(rate_vld_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rate after reset", rate_o, 64'd0);
      check("R1 valid after reset", 64'(rate_vld_o), 64'd0);

      for (int i = 0; i < 8; i++)
         run(VECS[i].rf, VECS[i].wd, VECS[i].pd, VECS[i].exp, "R3 R4 R5 R7 table");

      // R2: single pulse, then R6: inputs change without start
      run(32'd100, 22'(3 << 15), 3'd0, 64'd300, "R2 result");
      ref_freq_i = 32'd77; div_word_i = 22'h12345; post_sel_i = 3'd5;
      @(negedge clk);
      check("R2 pulse ends", 64'(rate_vld_o), 64'd0);
      check("R6 hold", rate_o, 64'd300);
      @(negedge clk);
      check("R6 hold later", rate_o, 64'd300);

      // R2: back-to-back starts give back-to-back results
      @(negedge clk);
      ref_freq_i = 32'd10; div_word_i = 22'(5 << 15); post_sel_i = 3'd0; start_i = 1'b1;
      @(negedge clk);
      check("R2 first of pair", rate_o, 64'd50);
      ref_freq_i = 32'd10; div_word_i = 22'(7 << 15);
      @(negedge clk);
      start_i = 1'b0;
      check("R2 second of pair", rate_o, 64'd70);
      check("R2 valid held", 64'(rate_vld_o), 64'd1);

      // R7 zero word, widest product at largest divide
      run(32'hFFFFFFFF, 22'd0, 3'd4, 64'd0, "R7 zero word");
      run(32'hFFFFFFFF, 22'h3FFFFF, 3'd7, 64'(model(64'hFFFFFFFF, 64'h3FFFFF, 7)), "R5 max");

      // R4 R5 random words, including fraction-free ones
      for (int i = 0; i < 60; i++) begin
         logic [31:0] rf;
         logic [21:0] wd;
         logic [2:0]  pd;
         rf = $urandom;
         wd = 22'($urandom);
         if (i % 4 == 0) wd[FR-1:0] = '0;
         pd = 3'($urandom);
         run(rf, wd, pd, 64'(model(64'(rf), 64'(wd), int'(pd))), "R4 R5 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule